// File: doc/BRIEF.md
# Memory-Mapped Terminal I/O Controller

This peripheral connects a keyboard-style byte source and a display-style byte sink to a simple word-addressed processor bus. Software sees four 32-bit registers at offsets 0x0, 0x4, 0x8 and 0xC from a base address. Offset 0x0 is receiver status/control and 0x4 is receiver data. Offset 0x8 is transmitter status/control and 0xC is transmitter data. Bit 0 of each control word is a Ready flag and bit 1 is an interrupt enable. The Ready flags change only as side effects of device traffic and data-register accesses. Software can poll them, or can set the enables so that the block raises a level interrupt whenever a Ready flag is set.

On the device side, incoming characters arrive on a one-cycle valid strobe with no back-pressure. The receiver always accepts a character, and a newer one replaces an unread older one. Outgoing characters leave on a valid/ready stream. Once valid is raised, the byte and valid stay unchanged until the sink returns ready in the same cycle, and only that cycle completes the transfer. The sink may hold ready low for as long as it likes. While a character is waiting, the transmitter stays not-Ready and ignores further data writes.

Top module: `mmio_term_ctrl`

## Requirements
- R1: After reset the receiver control word reads 0, the transmitter control word reads 1 (Ready set, enable clear), `irq` is 0 and `disp_valid` is 0.
- R2: A cycle with `kb_valid` high stores `kb_byte`. The receiver control word then reads bit 0 = 1, and the receiver data word returns the byte in bits 7:0 with bits 31:8 zero.
- R3: A read of the receiver data word clears receiver Ready from the next cycle on. If `kb_valid` is high in the same cycle, the read returns the old byte and the new byte is stored with Ready set.
- R4: A new incoming byte overwrites an unread one, and the receiver data word returns the newest byte.
- R5: A write to the transmitter data word while transmitter Ready is 1 raises `disp_valid` from the next cycle on, with `disp_byte` equal to write-data bits 7:0. Transmitter Ready then reads 0.
- R6: While `disp_valid` is high and `disp_ready` is low, `disp_valid` and `disp_byte` hold, and data writes are ignored. After the cycle in which both are high, `disp_valid` is 0 and transmitter Ready reads 1.
- R7: A write to a control word changes only its bit 1 (interrupt enable). Ready is not writable, and bits 31:2 of a control word read as zero.
- R8: `irq` is 1 exactly when (receiver Ready AND receiver enable) OR (transmitter Ready AND transmitter enable).
- R9: Accesses with address bits 31:4 differing from the base are ignored. Writes change nothing, reads return 0, and reads do not clear receiver Ready.
- R10: The window base is parameter `BASE_ADDR` (default 0xFFFF0000), with the four registers selected by address bits 3:2 in the order receiver control, receiver data, transmitter control, transmitter data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, valid while `bus_rd` is high |
| kb_valid | input | 1 | Incoming character strobe |
| kb_byte | input | 8 | Incoming character |
| disp_valid | output | 1 | Outgoing character valid |
| disp_byte | output | 8 | Outgoing character |
| disp_ready | input | 1 | Sink accepts the outgoing character |
| irq | output | 1 | Level interrupt request |

## Verification
The receiver path is driven with four patterns: a single character, two characters before any read, a character that lands in the same cycle as a data read, and a character followed by an out-of-window read. Together these separate correct clear-on-read behaviour from loss of a racing byte, from failure to overwrite, and from decode leaks. The transmitter is held back by a low `disp_ready` for several cycles, and a second write is made while it is busy. This exposes any byte that changes before acceptance and any early return of Ready. The enable bits are set with all-ones write data in both states of Ready, so a writable Ready flag or a wrongly gated interrupt shows up.

// File: rtl/mmio_term_pkg.sv
package mmio_term_pkg;
  typedef enum logic [1:0] {
    REG_RX_CTRL = 2'd0,
    REG_RX_DATA = 2'd1,
    REG_TX_CTRL = 2'd2,
    REG_TX_DATA = 2'd3
  } term_reg_e;

  localparam int NUM_REGS = 4;
  localparam int RDY_BIT  = 0;
  localparam int IE_BIT   = 1;
endpackage

// File: rtl/mmio_term_dec.sv
module mmio_term_dec
  import mmio_term_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter logic [31:0] BASE_ADDR = 32'hFFFF_0000
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                rd,
  input  logic                wr,
  output logic                in_win,
  output term_reg_e           idx,
  output logic [NUM_REGS-1:0] rd_sel,
  output logic [NUM_REGS-1:0] wr_sel
);
  localparam int TAG_LSB = 4;

  assign in_win = (addr[ADDR_W-1:TAG_LSB] == BASE_ADDR[ADDR_W-1:TAG_LSB]);
  assign idx    = term_reg_e'(addr[TAG_LSB-1:2]);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    assign rd_sel[g] = in_win && rd && (idx == term_reg_e'(g));
    assign wr_sel[g] = in_win && wr && (idx == term_reg_e'(g));
  end
endmodule

// File: rtl/mmio_term_rx.sv
module mmio_term_rx #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_char,
  input  logic              ctrl_wr,
  input  logic              ie_wdata,
  input  logic              data_rd,
  output logic              rdy,
  output logic              ie,
  output logic [CHAR_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy  <= 1'b0;
      ie   <= 1'b0;
      data <= '0;
    end else begin
      if (in_valid) begin
        data <= in_char;
        rdy  <= 1'b1;
      end else if (data_rd) begin
        rdy <= 1'b0;
      end
      if (ctrl_wr) ie <= ie_wdata;
    end
  end
endmodule

// File: rtl/mmio_term_tx.sv
module mmio_term_tx #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              ie_wdata,
  input  logic              data_wr,
  input  logic [CHAR_W-1:0] wchar,
  output logic              out_valid,
  output logic [CHAR_W-1:0] out_char,
  input  logic              out_ready,
  output logic              rdy,
  output logic              ie
);
  logic pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      out_char <= '0;
      ie       <= 1'b0;
    end else begin
      if (pend) begin
        if (out_ready) pend <= 1'b0;
      end else if (data_wr) begin
        pend     <= 1'b1;
        out_char <= wchar;
      end
      if (ctrl_wr) ie <= ie_wdata;
    end
  end

  assign out_valid = pend;
  assign rdy       = ~pend;
endmodule

// File: rtl/mmio_term_ctrl.sv
module mmio_term_ctrl
  import mmio_term_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          DATA_W    = 32,
  parameter int          CHAR_W    = 8,
  parameter logic [31:0] BASE_ADDR = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              kb_valid,
  input  logic [CHAR_W-1:0] kb_byte,
  output logic              disp_valid,
  output logic [CHAR_W-1:0] disp_byte,
  input  logic              disp_ready,
  output logic              irq
);
  logic                in_win;
  term_reg_e           idx;
  logic [NUM_REGS-1:0] rd_sel;
  logic [NUM_REGS-1:0] wr_sel;
  logic                rx_rdy, rx_ie, tx_rdy, tx_ie;
  logic [CHAR_W-1:0]   rx_data;

  mmio_term_dec #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) dec_i (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
    .in_win(in_win), .idx(idx), .rd_sel(rd_sel), .wr_sel(wr_sel)
  );

  mmio_term_rx #(.CHAR_W(CHAR_W)) rx_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(kb_valid), .in_char(kb_byte),
    .ctrl_wr(wr_sel[REG_RX_CTRL]), .ie_wdata(bus_wdata[IE_BIT]),
    .data_rd(rd_sel[REG_RX_DATA]),
    .rdy(rx_rdy), .ie(rx_ie), .data(rx_data)
  );

  mmio_term_tx #(.CHAR_W(CHAR_W)) tx_i (
    .clk(clk), .rst_n(rst_n),
    .ctrl_wr(wr_sel[REG_TX_CTRL]), .ie_wdata(bus_wdata[IE_BIT]),
    .data_wr(wr_sel[REG_TX_DATA]), .wchar(bus_wdata[CHAR_W-1:0]),
    .out_valid(disp_valid), .out_char(disp_byte), .out_ready(disp_ready),
    .rdy(tx_rdy), .ie(tx_ie)
  );

  always_comb begin
    bus_rdata = '0;
    if (in_win && bus_rd) begin
      unique case (idx)
        REG_RX_CTRL: begin
          bus_rdata[RDY_BIT] = rx_rdy;
          bus_rdata[IE_BIT]  = rx_ie;
        end
        REG_RX_DATA: bus_rdata[CHAR_W-1:0] = rx_data;
        REG_TX_CTRL: begin
          bus_rdata[RDY_BIT] = tx_rdy;
          bus_rdata[IE_BIT]  = tx_ie;
        end
        default: ;
      endcase
    end
  end

  assign irq = (rx_rdy & rx_ie) | (tx_rdy & tx_ie);
endmodule

// File: rtl/mmio_term_chk.sv
module mmio_term_chk #(
  parameter logic [31:0] BASE_ADDR = 32'hFFFF_0000
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] bus_addr,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic [31:0] bus_wdata,
  input logic        kb_valid,
  input logic        disp_valid,
  input logic [7:0]  disp_byte,
  input logic        disp_ready,
  input logic        irq,
  input logic        rx_rdy,
  input logic        rx_ie,
  input logic        tx_rdy,
  input logic        tx_ie
);
  logic win;
  assign win = (bus_addr[31:4] == BASE_ADDR[31:4]);

  AST_RX_SET: assert property (@(posedge clk) disable iff (!rst_n)
    kb_valid |=> rx_rdy); // R2

  AST_RX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && win && bus_addr[3:2] == 2'd1 && !kb_valid) |=> !rx_rdy); // R3

  AST_TX_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && win && bus_addr[3:2] == 2'd3 && tx_rdy)
      |=> (disp_valid && !tx_rdy && disp_byte == $past(bus_wdata[7:0]))); // R5

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_ready) |=> (disp_valid && $stable(disp_byte))); // R6

  AST_TX_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready) |=> (!disp_valid && tx_rdy)); // R6

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_ie && !tx_ie) |-> !irq); // R8

  AST_OUTSIDE_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !win) |=> ($stable(rx_ie) && $stable(tx_ie))); // R9
endmodule

bind mmio_term_ctrl mmio_term_chk #(.BASE_ADDR(BASE_ADDR)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_wr(bus_wr), .bus_wdata(bus_wdata), .kb_valid(kb_valid),
  .disp_valid(disp_valid), .disp_byte(disp_byte), .disp_ready(disp_ready),
  .irq(irq), .rx_rdy(rx_rdy), .rx_ie(rx_ie), .tx_rdy(tx_rdy), .tx_ie(tx_ie)
);

// File: tb/mmio_term_ctrl_tb_top.sv
module mmio_term_ctrl_tb_top;
  localparam logic [31:0] BASE = 32'hFFFF_0000;
  localparam logic [31:0] A_RXC = BASE + 32'h0;
  localparam logic [31:0] A_RXD = BASE + 32'h4;
  localparam logic [31:0] A_TXC = BASE + 32'h8;
  localparam logic [31:0] A_TXD = BASE + 32'hC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        kb_valid = 1'b0;
  logic [7:0]  kb_byte = '0;
  logic        disp_valid;
  logic [7:0]  disp_byte;
  logic        disp_ready = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  mmio_term_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .kb_valid(kb_valid), .kb_byte(kb_byte), .disp_valid(disp_valid),
    .disp_byte(disp_byte), .disp_ready(disp_ready), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic kb(input logic [7:0] b);
    @(negedge clk);
    kb_valid = 1'b1; kb_byte = b;
    @(negedge clk);
    kb_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(A_RXC, d); check("R1 rx ctrl", d, 32'h0);
    rd(A_TXC, d); check("R1 tx ctrl", d, 32'h1);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 disp_valid", {31'b0, disp_valid}, 32'h0);
  endtask

  task automatic t_rx_basic;
    logic [31:0] d;
    kb(8'hA5);
    rd(A_RXC, d); check("R2 rx ready set", d, 32'h1);
    rd(A_RXD, d); check("R2/R10 rx data", d, 32'h0000_00A5);
    rd(A_RXC, d); check("R3 ready cleared by read", d, 32'h0);
  endtask

  task automatic t_rx_overwrite;
    logic [31:0] d;
    kb(8'h11);
    kb(8'h22);
    rd(A_RXD, d); check("R4 newest byte", d, 32'h22);
    rd(A_RXC, d); check("R4 ready cleared", d, 32'h0);
  endtask

  task automatic t_rx_race;
    logic [31:0] d;
    kb(8'h5C);
    @(negedge clk);
    bus_addr = A_RXD; bus_rd = 1'b1; kb_valid = 1'b1; kb_byte = 8'h33;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0; kb_valid = 1'b0;
    check("R3 race read returns old", d, 32'h5C);
    rd(A_RXC, d); check("R3 race ready kept", d, 32'h1);
    rd(A_RXD, d); check("R3 race new byte", d, 32'h33);
  endtask

  task automatic t_tx;
    logic [31:0] d;
    disp_ready = 1'b0;
    wr(A_TXD, 32'h1234_56C3);
    check("R5 disp_valid", {31'b0, disp_valid}, 32'h1);
    check("R5 disp_byte", {24'b0, disp_byte}, 32'hC3);
    rd(A_TXC, d); check("R5 tx ready low", d, 32'h0);
    idle(3);
    wr(A_TXD, 32'h7E);
    check("R6 hold valid", {31'b0, disp_valid}, 32'h1);
    check("R6 busy write ignored", {24'b0, disp_byte}, 32'hC3);
    @(negedge clk);
    disp_ready = 1'b1;
    @(negedge clk);
    disp_ready = 1'b0;
    check("R6 valid dropped", {31'b0, disp_valid}, 32'h0);
    rd(A_TXC, d); check("R6 tx ready back", d, 32'h1);
  endtask

  task automatic t_ctrl_irq;
    logic [31:0] d;
    wr(A_RXC, 32'hFFFF_FFFF);
    rd(A_RXC, d); check("R7 only enable written", d, 32'h2);
    check("R8 rx enabled, not ready", {31'b0, irq}, 32'h0);
    wr(A_TXC, 32'hFFFF_FFFE);
    rd(A_TXC, d); check("R7 tx ctrl", d, 32'h3);
    check("R8 tx irq", {31'b0, irq}, 32'h1);
    wr(A_TXC, 32'h0);
    check("R8 tx irq off", {31'b0, irq}, 32'h0);
    kb(8'h41);
    check("R8 rx irq", {31'b0, irq}, 32'h1);
    rd(A_RXD, d);
    check("R8 rx irq cleared", {31'b0, irq}, 32'h0);
    wr(A_RXC, 32'h0);
  endtask

  task automatic t_window;
    logic [31:0] d;
    wr(32'hFFFE_0008, 32'h2);
    rd(A_TXC, d); check("R9 outside write ignored", d, 32'h1);
    check("R9 irq", {31'b0, irq}, 32'h0);
    kb(8'h99);
    rd(32'hFFFF_0014, d); check("R9 outside read zero", d, 32'h0);
    rd(A_RXC, d); check("R9 no clear from outside read", d, 32'h1);
    rd(A_RXD, d); check("R10 data offset", d, 32'h99);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_rx_basic();
    t_rx_overwrite();
    t_rx_race();
    t_tx();
    t_ctrl_irq();
    t_window();
    idle(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule